// File: doc/BRIEF.md
# Compiler-Sequenced Tile Crossbar Switch

This block is the routing switch of one tile in a grid of tiles. It has five ports: four neighbour links (north, south, east, west) and the local processor. A small program in its own instruction memory drives it, with its own program counter. Each instruction chooses, for every output port, which input port (if any) feeds it. All the routes that an instruction names move one word each, and they move together in one cycle. The switch never makes a routing decision of its own. Software plans all traffic ahead of time.

Every port has a four-entry input FIFO and a four-entry output FIFO of 32-bit words. A route instruction waits, with its program counter held, until every source it reads has a word and every destination it writes has space. It then moves all of its words in one cycle. The processor reaches the switch through a window of register numbers. Writing one of them pushes a word toward the switch. Reading one of them pops a word the switch delivered. The processor is stalled when the access cannot complete.

The program is written through a load port while reset is held. The switch starts at address 0 when reset is released.

Top module: `tile_route_switch`

## Requirements
- R1: While reset is held and just after it is released, every neighbour output valid is 0, every neighbour input ready is 1, and execution starts at program address 0.
- R2: Program memory writes are accepted only while rst_n is 0. Writes presented while rst_n is 1 have no effect on routing.
- R3: A ROUTE instruction moves words only in a cycle where every named source FIFO is non-empty and every named destination FIFO is non-full. Otherwise no word moves and the instruction is retried. A word that has arrived for one of its routes is not forwarded alone.
- R4: All routes of one instruction transfer in the same cycle. A source named by several outputs (multicast) delivers the same word to each of them and is consumed once.
- R5: The instruction word is {target[PC_W-1:0], op[1:0], selP, selW, selE, selS, selN}. Each sel field is 3 bits: 0 means none, 1 north, 2 south, 3 east, 4 west, 5 processor; codes 6 and 7 mean none.
- R6: op 0 (ROUTE) advances the program counter by one after firing. op 1 (JUMP) loads target with no transfer. op 2 or 3 (HALT) stops the switch until the next reset.
- R7: Each FIFO holds 4 words in arrival order. A neighbour input drops ready once its FIFO holds 4 words.
- R8: Processor reads and writes to register numbers 24 to 27 pop from the processor receive FIFO and push to the processor send FIFO. Other register numbers cause no transfer and no stall.
- R9: cpu_stall is 1 in a cycle where a network register read meets an empty receive FIFO or a network register write meets a full send FIFO. The stalled access transfers nothing.
- R10: A neighbour output presents the head of its FIFO with valid set. The word is removed on a clock edge where valid and ready are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; program load window |
| prog_we | input | 1 | Program memory write strobe (honoured only in reset) |
| prog_addr | input | PC_W | Program memory write address |
| prog_data | input | INSTR_W | Program memory write word |
| nb_in_valid | input | 4 | Neighbour input valid, bit 0 N, 1 S, 2 E, 3 W |
| nb_in_data | input | 4*DATA_W | Neighbour input words, lane d at [d*DATA_W +: DATA_W] |
| nb_in_ready | output | 4 | Neighbour input FIFO has space |
| nb_out_valid | output | 4 | Neighbour output FIFO non-empty |
| nb_out_data | output | 4*DATA_W | Neighbour output words (FIFO heads) |
| nb_out_ready | input | 4 | Neighbour accepts the output word |
| cpu_rd_en | input | 1 | Processor reads a register |
| cpu_rd_reg | input | REG_W | Register number read |
| cpu_rd_data | output | DATA_W | Head of the processor receive FIFO |
| cpu_wr_en | input | 1 | Processor writes a register |
| cpu_wr_reg | input | REG_W | Register number written |
| cpu_wr_data | input | DATA_W | Word written |
| cpu_stall | output | 1 | Network register access cannot complete this cycle |

## Verification
A wrong program counter shows up at the ports as soon as the next word arrives. That word leaves on the wrong neighbour, or never leaves, and the per-port scoreboard flags an unexpected or missing word. A wrong FIFO occupancy shows on the next edge as a ready or valid level that differs from the count of words the bench pushed and drained. That count covers the full-input and halted cases. A firing decision that lets one route of a multi-route instruction move early puts a word on an output while its partner source is still empty. The bench watches for this over ten idle cycles.

// File: rtl/tile_route_switch_pkg.sv
package tile_route_switch_pkg;
  localparam int NPORT = 5;
  localparam int SEL_W = 3;
  localparam int SEL_FIELD_W = NPORT * SEL_W;
  localparam int OP_LSB = SEL_FIELD_W;
  localparam int TGT_LSB = SEL_FIELD_W + 2;

  typedef enum logic [1:0] {
    OP_ROUTE = 2'd0,
    OP_JUMP  = 2'd1,
    OP_HALT  = 2'd2,
    OP_HALT2 = 2'd3
  } sw_op_e;

  // Select code for output o out of the packed select field.
  function automatic logic [SEL_W-1:0] sel_for(input logic [SEL_FIELD_W-1:0] f, input int o);
    return f[o*SEL_W +: SEL_W];
  endfunction

  // Codes 1..NPORT name a source port; all others mean "no route".
  function automatic logic sel_live(input logic [SEL_W-1:0] s);
    return (s != '0) && (s <= SEL_W'(NPORT));
  endfunction

  function automatic logic [SEL_W-1:0] sel_src(input logic [SEL_W-1:0] s);
    return s - SEL_W'(1);
  endfunction
endpackage

// File: rtl/tsw_fifo.sv
module tsw_fifo #(
  parameter int W = 32,
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign head  = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
endmodule

// File: rtl/tsw_sequencer.sv
module tsw_sequencer
  import tile_route_switch_pkg::*;
#(
  parameter int PROG_DEPTH = 16,
  localparam int PC_W = $clog2(PROG_DEPTH),
  localparam int INSTR_W = TGT_LSB + PC_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   prog_we,
  input  logic [PC_W-1:0]        prog_addr,
  input  logic [INSTR_W-1:0]     prog_data,
  input  logic                   fire,
  output logic                   route_en,
  output logic [SEL_FIELD_W-1:0] sel_field
);
  logic [INSTR_W-1:0] prog_mem [PROG_DEPTH];
  logic [PC_W-1:0]    pc;
  logic [INSTR_W-1:0] instr;
  sw_op_e             op;
  logic [PC_W-1:0]    target;

  // Loading is only possible while the switch is held in reset.
  always_ff @(posedge clk) begin
    if (!rst_n && prog_we) prog_mem[prog_addr] <= prog_data;
  end

  assign instr     = prog_mem[pc];
  assign op        = sw_op_e'(instr[OP_LSB +: 2]);
  assign target    = instr[TGT_LSB +: PC_W];
  assign sel_field = instr[SEL_FIELD_W-1:0];
  assign route_en  = (op == OP_ROUTE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
    end else begin
      case (op)
        OP_ROUTE: if (fire) pc <= pc + PC_W'(1);
        OP_JUMP:  pc <= target;
        default:  pc <= pc;
      endcase
    end
  end

  assert_pc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ROUTE && !fire) |=> $stable(pc));
  assert_jump_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_JUMP) |=> (pc == $past(target)));
  assert_halt_sticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_HALT || op == OP_HALT2) |=> ($stable(pc) && !route_en));
endmodule

// File: rtl/tsw_xbar.sv
module tsw_xbar
  import tile_route_switch_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                   route_en,
  input  logic [SEL_FIELD_W-1:0] sel_field,
  input  logic [W-1:0]           src_data [NPORT],
  input  logic [NPORT-1:0]       src_empty,
  input  logic [NPORT-1:0]       dst_full,
  output logic                   fire,
  output logic [NPORT-1:0]       src_pop,
  output logic [NPORT-1:0]       dst_push,
  output logic [W-1:0]           dst_data [NPORT]
);
  logic             all_ok;
  logic [NPORT-1:0] used;

  always_comb begin
    all_ok = 1'b1;
    used   = '0;
    for (int o = 0; o < NPORT; o++) begin
      logic [SEL_W-1:0] s;
      s = sel_for(sel_field, o);
      if (sel_live(s)) begin
        used[sel_src(s)] = 1'b1;
        if (src_empty[sel_src(s)] || dst_full[o]) all_ok = 1'b0;
      end
    end
    fire = route_en && all_ok;
  end

  always_comb begin
    for (int o = 0; o < NPORT; o++) begin
      logic [SEL_W-1:0] s;
      s = sel_for(sel_field, o);
      dst_push[o] = fire && sel_live(s);
      dst_data[o] = sel_live(s) ? src_data[sel_src(s)] : '0;
    end
    src_pop = fire ? used : '0;
  end
endmodule

// File: rtl/tsw_cpu_port.sv
module tsw_cpu_port #(
  parameter int REG_W = 5,
  parameter int NET_LO = 24,
  parameter int NET_HI = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [REG_W-1:0] rd_reg,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_reg,
  input  logic             rx_empty,
  input  logic             tx_full,
  output logic             rx_pop,
  output logic             tx_push,
  output logic             stall
);
  function automatic logic is_net(input logic [REG_W-1:0] r);
    return (r >= REG_W'(NET_LO)) && (r <= REG_W'(NET_HI));
  endfunction

  logic rd_hit, wr_hit;
  assign rd_hit  = rd_en && is_net(rd_reg);
  assign wr_hit  = wr_en && is_net(wr_reg);
  assign stall   = (rd_hit && rx_empty) || (wr_hit && tx_full);
  assign rx_pop  = rd_hit && !stall;
  assign tx_push = wr_hit && !stall;

  assert_stall_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (rx_empty || tx_full));
endmodule

// File: rtl/tile_route_switch.sv
module tile_route_switch
  import tile_route_switch_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int PROG_DEPTH = 16,
  parameter int REG_W = 5,
  parameter int NET_LO = 24,
  parameter int NET_HI = 27,
  localparam int PC_W = $clog2(PROG_DEPTH),
  localparam int INSTR_W = TGT_LSB + PC_W,
  localparam int NNB = NPORT - 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  prog_we,
  input  logic [PC_W-1:0]       prog_addr,
  input  logic [INSTR_W-1:0]    prog_data,
  input  logic [NNB-1:0]        nb_in_valid,
  input  logic [NNB*DATA_W-1:0] nb_in_data,
  output logic [NNB-1:0]        nb_in_ready,
  output logic [NNB-1:0]        nb_out_valid,
  output logic [NNB*DATA_W-1:0] nb_out_data,
  input  logic [NNB-1:0]        nb_out_ready,
  input  logic                  cpu_rd_en,
  input  logic [REG_W-1:0]      cpu_rd_reg,
  output logic [DATA_W-1:0]     cpu_rd_data,
  input  logic                  cpu_wr_en,
  input  logic [REG_W-1:0]      cpu_wr_reg,
  input  logic [DATA_W-1:0]     cpu_wr_data,
  output logic                  cpu_stall
);
  localparam int CPU = NPORT - 1;

  logic [DATA_W-1:0]      in_head  [NPORT];
  logic [DATA_W-1:0]      in_wdata [NPORT];
  logic [DATA_W-1:0]      out_head [NPORT];
  logic [DATA_W-1:0]      xb_data  [NPORT];
  logic [NPORT-1:0]       in_push, in_pop, in_full, in_empty;
  logic [NPORT-1:0]       out_push, out_pop, out_full, out_empty;
  logic                   route_en, xb_fire;
  logic [SEL_FIELD_W-1:0] sel_field;
  logic                   cpu_rx_pop, cpu_tx_push;

  tsw_sequencer #(.PROG_DEPTH(PROG_DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .fire(xb_fire), .route_en(route_en), .sel_field(sel_field)
  );

  tsw_xbar #(.W(DATA_W)) u_xbar (
    .route_en(route_en), .sel_field(sel_field), .src_data(in_head),
    .src_empty(in_empty), .dst_full(out_full), .fire(xb_fire),
    .src_pop(in_pop), .dst_push(out_push), .dst_data(xb_data)
  );

  tsw_cpu_port #(.REG_W(REG_W), .NET_LO(NET_LO), .NET_HI(NET_HI)) u_cpu (
    .clk(clk), .rst_n(rst_n), .rd_en(cpu_rd_en), .rd_reg(cpu_rd_reg),
    .wr_en(cpu_wr_en), .wr_reg(cpu_wr_reg), .rx_empty(out_empty[CPU]),
    .tx_full(in_full[CPU]), .rx_pop(cpu_rx_pop), .tx_push(cpu_tx_push), .stall(cpu_stall)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    if (p < NNB) begin : g_nb
      assign in_wdata[p]  = nb_in_data[p*DATA_W +: DATA_W];
      assign in_push[p]   = nb_in_valid[p] && !in_full[p];
      assign nb_in_ready[p] = !in_full[p];
      assign nb_out_valid[p] = !out_empty[p];
      assign nb_out_data[p*DATA_W +: DATA_W] = out_head[p];
      assign out_pop[p]   = !out_empty[p] && nb_out_ready[p];
    end else begin : g_cpu
      assign in_wdata[p]  = cpu_wr_data;
      assign in_push[p]   = cpu_tx_push;
      assign out_pop[p]   = cpu_rx_pop;
      assign cpu_rd_data  = out_head[p];
    end

    tsw_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_in (
      .clk(clk), .rst_n(rst_n), .push(in_push[p]), .push_data(in_wdata[p]),
      .pop(in_pop[p]), .head(in_head[p]), .full(in_full[p]), .empty(in_empty[p])
    );
    tsw_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_out (
      .clk(clk), .rst_n(rst_n), .push(out_push[p]), .push_data(xb_data[p]),
      .pop(out_pop[p]), .head(out_head[p]), .full(out_full[p]), .empty(out_empty[p])
    );
  end

  assert_src_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_pop & in_empty) == '0) && ((out_push & out_full) == '0));
  assert_pop_needs_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pop != '0) |-> (out_push != '0));
endmodule

// File: tb/tile_route_switch_tb.sv
module tile_route_switch_tb;
  localparam int DW = 32;
  localparam int N = 0, S = 1, E = 2, W = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         prog_we = 1'b0;
  logic [3:0]   prog_addr = '0;
  logic [20:0]  prog_data = '0;
  logic [3:0]   nb_in_valid = '0;
  logic [127:0] nb_in_data = '0;
  logic [3:0]   nb_in_ready;
  logic [3:0]   nb_out_valid;
  logic [127:0] nb_out_data;
  logic [3:0]   nb_out_ready = 4'hf;
  logic         cpu_rd_en = 1'b0;
  logic [4:0]   cpu_rd_reg = '0;
  logic [31:0]  cpu_rd_data;
  logic         cpu_wr_en = 1'b0;
  logic [4:0]   cpu_wr_reg = '0;
  logic [31:0]  cpu_wr_data = '0;
  logic         cpu_stall;

  int checks = 0;
  int errs = 0;
  string cur_req = "R10";
  logic [31:0] exp_q [4][$];

  always #4 clk = ~clk;

  tile_route_switch u_dut (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
    .nb_in_valid(nb_in_valid), .nb_in_data(nb_in_data), .nb_in_ready(nb_in_ready),
    .nb_out_valid(nb_out_valid), .nb_out_data(nb_out_data), .nb_out_ready(nb_out_ready),
    .cpu_rd_en(cpu_rd_en), .cpu_rd_reg(cpu_rd_reg), .cpu_rd_data(cpu_rd_data),
    .cpu_wr_en(cpu_wr_en), .cpu_wr_reg(cpu_wr_reg), .cpu_wr_data(cpu_wr_data),
    .cpu_stall(cpu_stall)
  );

  // R5 encoding: {target, op, selP, selW, selE, selS, selN}
  function automatic logic [20:0] enc(input logic [1:0] op, input logic [3:0] tgt,
      input logic [2:0] sn, input logic [2:0] ss, input logic [2:0] se,
      input logic [2:0] sw, input logic [2:0] sp);
    return {tgt, op, sp, sw, se, ss, sn};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: every word leaving a neighbour port is compared.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int d = 0; d < 4; d++) begin
        if (nb_out_valid[d] && nb_out_ready[d]) begin
          if (exp_q[d].size() == 0) begin
            chk({cur_req, " unexpected word"}, nb_out_data[d*DW +: DW], 32'hxxxxxxxx);
          end else begin
            chk(cur_req, nb_out_data[d*DW +: DW], exp_q[d].pop_front());
          end
        end
      end
    end
  end

  task automatic send(input int d, input logic [31:0] v);
    @(negedge clk);
    nb_in_valid[d] = 1'b1;
    nb_in_data[d*DW +: DW] = v;
    while (!nb_in_ready[d]) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    nb_in_valid[d] = 1'b0;
  endtask

  task automatic cpu_write(input logic [4:0] r, input logic [31:0] v);
    @(negedge clk);
    cpu_wr_en = 1'b1; cpu_wr_reg = r; cpu_wr_data = v;
    while (cpu_stall) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cpu_wr_en = 1'b0;
  endtask

  task automatic cpu_read(input logic [4:0] r, input logic [31:0] v, input string req);
    @(negedge clk);
    cpu_rd_en = 1'b1; cpu_rd_reg = r;
    while (cpu_stall) @(negedge clk);
    chk(req, cpu_rd_data, v);
    @(posedge clk);
    @(negedge clk);
    cpu_rd_en = 1'b0;
  endtask

  task automatic restart(input logic [20:0] p0, input logic [20:0] p1,
      input logic [20:0] p2, input logic [20:0] p3);
    @(negedge clk);
    rst_n = 1'b0;
    for (int a = 0; a < 4; a++) begin
      @(negedge clk);
      prog_we = 1'b1; prog_addr = 4'(a);
      prog_data = (a == 0) ? p0 : (a == 1) ? p1 : (a == 2) ? p2 : p3;
    end
    @(negedge clk);
    prog_we = 1'b0;
    chk("R1 out valid in reset", 32'(nb_out_valid), 32'h0);
    chk("R1 in ready in reset", 32'(nb_in_ready), 32'hf);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end

  initial begin
    // Phase A: loop of three route steps then JUMP 0 (R5/R6)
    restart(enc(2'd0, 4'd0, 3'd0, 3'd0, 3'd5, 3'd0, 3'd0),   // E <- P
            enc(2'd0, 4'd0, 3'd0, 3'd4, 3'd0, 3'd0, 3'd1),   // S <- W, P <- N
            enc(2'd0, 4'd0, 3'd3, 3'd0, 3'd0, 3'd3, 3'd0),   // N <- E, W <- E
            enc(2'd1, 4'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0));  // JUMP 0
    @(negedge clk);
    chk("R1 out valid after reset", 32'(nb_out_valid), 32'h0);
    chk("R1 in ready after reset", 32'(nb_in_ready), 32'hf);

    // R9: read of empty receive FIFO stalls
    cpu_rd_en = 1'b1; cpu_rd_reg = 5'd24;
    #1 chk("R9 read empty stalls", 32'(cpu_stall), 32'h1);
    @(negedge clk); cpu_rd_en = 1'b0;

    // R8: non-network register write moves nothing
    cur_req = "R8";
    cpu_write(5'd5, 32'h0bad0001);
    repeat (10) @(negedge clk);
    chk("R8 ignored write no output", 32'(nb_out_valid), 32'h0);
    exp_q[E].push_back(32'ha1a1a1a1);
    cpu_write(5'd25, 32'ha1a1a1a1);         // step 0 sends it east (R1 starts at 0)
    repeat (6) @(negedge clk);

    // R3: step 1 needs W and N; W alone must not move
    cur_req = "R3";
    send(W, 32'hb1b1b1b1);
    repeat (10) @(negedge clk);
    chk("R3 partial sources hold", 32'(nb_out_valid), 32'h0);
    exp_q[S].push_back(32'hb1b1b1b1);
    send(N, 32'hc1c1c1c1);
    repeat (6) @(negedge clk);
    cpu_rd_en = 1'b1; cpu_rd_reg = 5'd3;    // R8 ignored read
    @(negedge clk); cpu_rd_en = 1'b0;
    cpu_read(5'd27, 32'hc1c1c1c1, "R8 network read");

    // R4: multicast E -> N and W in the same cycle
    cur_req = "R4";
    exp_q[N].push_back(32'hd1d1d1d1);
    exp_q[W].push_back(32'hd1d1d1d1);
    send(E, 32'hd1d1d1d1);
    while (!nb_out_valid[N]) @(negedge clk);
    chk("R4 both outputs same cycle", 32'(nb_out_valid[W]), 32'h1);
    repeat (6) @(negedge clk);

    // R6: JUMP back to 0, east route works again
    cur_req = "R6";
    exp_q[E].push_back(32'ha2a2a2a2);
    cpu_write(5'd24, 32'ha2a2a2a2);
    repeat (8) @(negedge clk);
    chk("R6 queues drained after jump", 32'(exp_q[E].size()), 32'h0);

    // Phase B: E <- N loop; output full blocks (R3, R7); program write ignored (R2)
    restart(enc(2'd0, 4'd0, 3'd0, 3'd0, 3'd1, 3'd0, 3'd0),
            enc(2'd1, 4'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0),
            enc(2'd2, 4'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0),
            enc(2'd2, 4'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0));
    cur_req = "R2";
    @(negedge clk);
    prog_we = 1'b1; prog_addr = 4'd0;
    prog_data = enc(2'd0, 4'd0, 3'd0, 3'd0, 3'd0, 3'd1, 3'd0);   // would be W <- N
    @(negedge clk);
    prog_we = 1'b0;
    nb_out_ready[E] = 1'b0;
    for (int i = 0; i < 8; i++) send(N, 32'h10 + 32'(i));
    repeat (6) @(negedge clk);
    chk("R7 input full drops ready", 32'(nb_in_ready[N]), 32'h0);
    chk("R2 no west output", 32'(nb_out_valid[W]), 32'h0);
    chk("R10 east valid held", 32'(nb_out_valid[E]), 32'h1);
    for (int i = 0; i < 4; i++) cpu_write(5'd26, 32'h20 + 32'(i));
    cpu_wr_en = 1'b1; cpu_wr_reg = 5'd26;
    #1 chk("R9 write full stalls", 32'(cpu_stall), 32'h1);
    cpu_wr_reg = 5'd10;
    #1 chk("R8 other register no stall", 32'(cpu_stall), 32'h0);
    @(negedge clk); cpu_wr_en = 1'b0;
    cur_req = "R7";
    for (int i = 0; i < 8; i++) exp_q[E].push_back(32'h10 + 32'(i));
    nb_out_ready[E] = 1'b1;
    repeat (30) @(negedge clk);
    chk("R7 all eight delivered", 32'(exp_q[E].size()), 32'h0);

    // Phase C: one route then HALT (R6)
    restart(enc(2'd0, 4'd0, 3'd0, 3'd0, 3'd1, 3'd0, 3'd0),
            enc(2'd2, 4'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0),
            enc(2'd0, 4'd0, 3'd0, 3'd0, 3'd1, 3'd0, 3'd0),
            enc(2'd1, 4'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0));
    cur_req = "R6";
    exp_q[E].push_back(32'he0e0e0e0);
    send(N, 32'he0e0e0e0);
    for (int i = 0; i < 4; i++) send(N, 32'he1 + 32'(i));
    repeat (10) @(negedge clk);
    chk("R6 halted input stays full", 32'(nb_in_ready[N]), 32'h0);
    chk("R6 halted no output", 32'(nb_out_valid), 32'h0);

    repeat (5) @(negedge clk);
    for (int d = 0; d < 4; d++) chk("R10 scoreboard empty", 32'(exp_q[d].size()), 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end
endmodule